// File: doc/BRIEF.md
# Two-Wire Programming Link Master PHY

This block is the master end of a clocked, half-duplex, two-wire program and debug link. It owns a clock line and a bidirectional data line. The data line is represented by an output value, an output enable and a separate input sample. A host hands it one operation at a time. The operation is to send a byte, to receive a byte, or to run the link-entry sequence. When the operation is finished the block returns a one-cycle response that carries the received byte and an error flag.

Every byte on the wire travels in a 12-bit synchronous frame: a low start bit, eight data bits least-significant first, an even-parity bit, and two high stop bits. The link clock is derived from the system clock by a parameterized divider. One link-clock period is `2*HALF_DIV` system cycles. The link clock idles high, and each bit takes one link-clock pulse: a low half followed by a high half. On receive, the block releases the data line. It then keeps pulsing the clock while it hunts for a start bit, and gives up after `HUNT_LIMIT` pulses.

The request side follows valid/ready rules. A request transfers on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. While an operation is in flight, `cmd_ready` is low, and `cmd_valid` with its payload is ignored. The host may hold `cmd_valid` and the payload at any level during that time. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle and must be taken in that cycle.

Top module: `tw_link_phy`

## Requirements
- R1: A send transmits the 12-bit frame on `link_dout` in this order: bit 0 is a start bit of 0, bits 1..8 are the data LSB first, bit 9 is the XOR of the eight data bits, and bits 10..11 are stop bits of 1. Each bit is sampled at one rising edge of `link_clk`, so a frame has exactly 12 rising edges, and `link_doe` is high throughout.
- R2: `link_dout` changes only on the edge where `link_clk` falls, and it is stable across every rising edge of `link_clk`. Consecutive rising edges within an operation are exactly `2*HALF_DIV` system cycles apart.
- R3: `cmd_ready` is high exactly when the block is idle. The operation code is `cmd_op`: 2'b00 is send, 2'b01 is receive, and 2'b1x is link entry. `busy` goes high in the cycle after acceptance and stays high until the last link-clock pulse has finished. A `cmd_valid` seen while busy is ignored and does not change the frame in progress.
- R4: Every operation ends with `rsp_valid` high for one cycle, in the same cycle that `busy` falls. For send and entry operations, `rsp_err` is 0.
- R5: A receive drives `link_doe` low from the cycle after acceptance. It then hunts with clock pulses, and a low sample on `link_din` at the rising edge of any hunt pulse with index 0 to `HUNT_LIMIT-1` (256 by default) is taken as the start bit.
- R6: After the start bit, exactly 11 more pulses are given in every case. These sample the data LSB first, then parity, then two stop bits. A well-formed frame returns the byte on `rsp_data` with `rsp_err` 0.
- R7: A received parity bit that differs from the XOR of the data bits, or a stop bit sampled low, gives `rsp_err` 1 and `rsp_data` 0.
- R8: If no start bit is seen in `HUNT_LIMIT` hunt pulses, the receive ends after exactly that many pulses with `rsp_err` 1 and `rsp_data` 0.
- R9: Link entry proceeds in this order. First, data is driven to 0 while the clock is held high. Next, the clock and data outputs are enabled. Then data is raised to 1 with the clock still high. After that come 16 clock pulses with data at 1, followed at once by frames carrying 0xC2 and then 0x02. Both output enables remain high afterwards.
- R10: During reset, and right after it, `link_clk` is 1, `link_dout` is 1, `link_clk_oe` and `link_doe` are 0, `busy` and `rsp_valid` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle and able to accept a request |
| cmd_op | input | 2 | Operation: 00 send, 01 receive, 1x link entry |
| cmd_data | input | 8 | Byte to send |
| rsp_valid | output | 1 | One-cycle pulse marking the end of an operation |
| rsp_data | output | 8 | Received byte (0 on error or after send/entry) |
| rsp_err | output | 1 | Receive failure (parity, stop bit or start-bit timeout) |
| busy | output | 1 | Operation in flight |
| link_clk | output | 1 | Link clock value, idles high |
| link_clk_oe | output | 1 | Output enable for the link clock pad |
| link_dout | output | 1 | Data line value when driven |
| link_doe | output | 1 | Output enable for the data line pad |
| link_din | input | 1 | Sampled data line level |

## Verification
The hardest cases to reach from the ports are the receive-side edges: a start bit arriving on the very last permitted hunt pulse, a hunt that never sees one, and frames with a corrupted parity or stop bit. None of these can come from the block itself. The bench therefore contains a target model that follows the falling edges of `link_clk`. It stays high for a chosen number of pulses, then plays out a frame, which can be corrupted on purpose. This lets the start-bit delay be swept from 0 up to 255 and past the limit. For each receive, the bench counts the clock pulses the block gives. It also keeps `cmd_valid` asserted during a send in flight, to show that the frame on the wire is unchanged.

// File: rtl/tw_link_pkg.sv
package tw_link_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TX,
    S_RX_HUNT,
    S_RX_BITS,
    S_EN_LOW,
    S_EN_OE,
    S_EN_HI,
    S_EN_IDLE,
    S_EN_TXA,
    S_EN_TXB
  } tw_state_e;

  localparam int FRAME_BITS   = 12;
  localparam int TAIL_BITS    = 11;
  localparam int ENTRY_PULSES = 16;

  localparam logic [7:0] ENTRY_STORE_CMD = 8'hC2;
  localparam logic [7:0] ENTRY_STORE_VAL = 8'h02;

endpackage

// File: rtl/tw_pulse_gen.sv
module tw_pulse_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic fall,
  output logic sample,
  output logic pdone,
  output logic lclk
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  phase_e        ph_q;
  logic [HW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == HALF_LAST);
  assign fall   = go && ((ph_q == PH_IDLE) || ((ph_q == PH_HIGH) && last));
  assign sample = (ph_q == PH_LOW) && last;
  assign pdone  = (ph_q == PH_HIGH) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      lclk  <= 1'b1;
    end else if (fall) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
      lclk  <= 1'b0;
    end else if (sample) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
      lclk  <= 1'b1;
    end else if (pdone) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q != PH_IDLE) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tw_tx_frame.sv
module tw_tx_frame (
  input  logic [7:0]  byte_in,
  output logic [11:0] frame
);
  logic par;

  always_comb begin
    par = 1'b0;
    for (int i = 0; i < 8; i++) par = par ^ byte_in[i];
    frame = {2'b11, par, byte_in, 1'b0};
  end
endmodule

// File: rtl/tw_rx_check.sv
module tw_rx_check (
  input  logic [10:0] tail,
  output logic [7:0]  data,
  output logic        err
);
  logic par_bad;

  always_comb begin
    par_bad = 1'b0;
    for (int i = 0; i < 9; i++) par_bad = par_bad ^ tail[i];
    err  = par_bad || !tail[9] || !tail[10];
    data = err ? 8'h00 : tail[7:0];
  end
endmodule

// File: rtl/tw_link_phy.sv
module tw_link_phy
  import tw_link_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int HUNT_LIMIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_err,
  output logic       busy,
  output logic       link_clk,
  output logic       link_clk_oe,
  output logic       link_dout,
  output logic       link_doe,
  input  logic       link_din
);
  localparam int CW = (HUNT_LIMIT > ENTRY_PULSES) ? $clog2(HUNT_LIMIT) : $clog2(ENTRY_PULSES) + 1;
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST_FRAME = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] LAST_TAIL  = CW'(TAIL_BITS - 1);
  localparam logic [CW-1:0] LAST_ENTRY = CW'(ENTRY_PULSES - 1);
  localparam logic [CW-1:0] LAST_HUNT  = CW'(HUNT_LIMIT - 1);
  localparam logic [HW-1:0] WAIT_LAST  = HW'(HALF_DIV - 1);

  tw_state_e     state_q, state_nx;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] wcnt_q;
  logic [11:0]   tx_sh_q;
  logic [10:0]   rx_sh_q;
  logic          found_q;

  logic        accept, finish, pulsing, go, wait_end, in_wait;
  logic        fall, sample, pdone;
  logic        tx_next, tx_load;
  logic [7:0]  tx_byte;
  logic [11:0] new_frame, tx_src;
  logic [7:0]  chk_data;
  logic        chk_err;

  assign cmd_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign in_wait   = (state_q == S_EN_LOW) || (state_q == S_EN_OE) || (state_q == S_EN_HI);
  assign wait_end  = in_wait && (wcnt_q == WAIT_LAST);

  always_comb begin
    state_nx = state_q;
    finish   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          if (cmd_op[1])      state_nx = S_EN_LOW;
          else if (cmd_op[0]) state_nx = S_RX_HUNT;
          else                state_nx = S_TX;
        end
      end
      S_TX: begin
        if (pdone && cnt_q == LAST_FRAME) begin
          state_nx = S_IDLE;
          finish   = 1'b1;
        end
      end
      S_RX_HUNT: begin
        if (pdone) begin
          if (found_q) state_nx = S_RX_BITS;
          else if (cnt_q == LAST_HUNT) begin
            state_nx = S_IDLE;
            finish   = 1'b1;
          end
        end
      end
      S_RX_BITS: begin
        if (pdone && cnt_q == LAST_TAIL) begin
          state_nx = S_IDLE;
          finish   = 1'b1;
        end
      end
      S_EN_LOW:  if (wait_end) state_nx = S_EN_OE;
      S_EN_OE:   if (wait_end) state_nx = S_EN_HI;
      S_EN_HI:   if (wait_end) state_nx = S_EN_IDLE;
      S_EN_IDLE: if (pdone && cnt_q == LAST_ENTRY) state_nx = S_EN_TXA;
      S_EN_TXA:  if (pdone && cnt_q == LAST_FRAME) state_nx = S_EN_TXB;
      S_EN_TXB: begin
        if (pdone && cnt_q == LAST_FRAME) begin
          state_nx = S_IDLE;
          finish   = 1'b1;
        end
      end
      default: state_nx = S_IDLE;
    endcase
  end

  assign pulsing = (state_q == S_TX) || (state_q == S_RX_HUNT) || (state_q == S_RX_BITS) ||
                   (state_q == S_EN_IDLE) || (state_q == S_EN_TXA) || (state_q == S_EN_TXB);
  assign go      = pulsing && !finish;

  assign tx_next = (state_nx == S_TX) || (state_nx == S_EN_TXA) || (state_nx == S_EN_TXB);
  assign tx_load = tx_next && (state_nx != state_q);

  always_comb begin
    if (state_nx == S_EN_TXA)      tx_byte = ENTRY_STORE_CMD;
    else if (state_nx == S_EN_TXB) tx_byte = ENTRY_STORE_VAL;
    else                           tx_byte = cmd_data;
  end

  assign tx_src = tx_load ? new_frame : tx_sh_q;

  tw_pulse_gen #(.HALF_DIV(HALF_DIV)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .fall   (fall),
    .sample (sample),
    .pdone  (pdone),
    .lclk   (link_clk)
  );

  tw_tx_frame u_txf (
    .byte_in (tx_byte),
    .frame   (new_frame)
  );

  tw_rx_check u_rxc (
    .tail (rx_sh_q),
    .data (chk_data),
    .err  (chk_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_nx;
      if (accept || (pdone && state_nx != state_q)) cnt_q <= '0;
      else if (pdone)                               cnt_q <= cnt_q + 1'b1;
      if (!in_wait || wait_end) wcnt_q <= '0;
      else                      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q     <= '1;
      link_dout   <= 1'b1;
      link_doe    <= 1'b0;
      link_clk_oe <= 1'b0;
    end else begin
      if (accept) begin
        if (cmd_op[1]) begin
          link_dout <= 1'b0;
        end else begin
          link_clk_oe <= 1'b1;
          link_doe    <= !cmd_op[0];
        end
      end
      if (state_q == S_EN_LOW && wait_end) begin
        link_clk_oe <= 1'b1;
        link_doe    <= 1'b1;
      end
      if (state_q == S_EN_OE && wait_end) link_dout <= 1'b1;
      if (fall && tx_next) begin
        link_dout <= tx_src[0];
        tx_sh_q   <= {1'b1, tx_src[11:1]};
      end else if (tx_load) begin
        tx_sh_q <= tx_src;
      end else if (fall && state_nx == S_EN_IDLE) begin
        link_dout <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh_q   <= '0;
      found_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (accept) found_q <= 1'b0;
      else if (sample && state_q == S_RX_HUNT && !link_din) found_q <= 1'b1;
      if (sample && state_q == S_RX_BITS) rx_sh_q <= {link_din, rx_sh_q[10:1]};
      rsp_valid <= finish;
      if (finish) begin
        rsp_data <= (state_q == S_RX_BITS) ? chk_data : 8'h00;
        rsp_err  <= (state_q == S_RX_BITS) ? chk_err : (state_q == S_RX_HUNT);
      end
    end
  end
endmodule

// File: rtl/tw_link_phy_chk.sv
module tw_link_phy_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       rsp_err,
  input logic       link_clk,
  input logic       link_dout,
  input logic       link_doe
);
  assert_stable_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk) |-> $stable(link_dout));

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  assert_rsp_with_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $fell(busy));

  assert_release_on_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b01) |=> !link_doe);

  assert_err_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == 8'h00));
endmodule

bind tw_link_phy tw_link_phy_chk u_tw_link_phy_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err),
  .link_clk  (link_clk),
  .link_dout (link_dout),
  .link_doe  (link_doe)
);

// File: tb/tw_link_phy_bench.sv
`timescale 1ns/1ps
module tw_link_phy_bench;
  localparam int HD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, rsp_valid, rsp_err, busy;
  logic [7:0] rsp_data;
  logic       link_clk, link_clk_oe, link_dout, link_doe;
  logic       link_din = 1'b1;

  tw_link_phy #(.HALF_DIV(HD), .HUNT_LIMIT(256)) u_tw_link_phy (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .busy(busy), .link_clk(link_clk), .link_clk_oe(link_clk_oe),
    .link_dout(link_dout), .link_doe(link_doe), .link_din(link_din)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // monitor of rising link clock edges
  logic mon_b [0:319];
  logic mon_oe [0:319];
  time  mon_t [0:319];
  int   mon_n = 0;
  bit   mon_en = 0;
  always @(posedge link_clk) begin
    if (mon_en && mon_n < 320) begin
      mon_b[mon_n]  = link_dout;
      mon_oe[mon_n] = link_doe;
      mon_t[mon_n]  = $time;
      mon_n++;
    end
  end

  // target model: drives the data line after each falling link clock edge
  int          sl_k = 0;
  int          sl_delay = 0;
  logic [10:0] sl_frame = '1;
  bit          sl_en = 0;
  always @(negedge link_clk) begin
    if (sl_en) begin
      if (sl_k < sl_delay)                 link_din = 1'b1;
      else if (sl_k == sl_delay)           link_din = 1'b0;
      else if (sl_k - sl_delay - 1 < 11)   link_din = sl_frame[sl_k - sl_delay - 1];
      else                                 link_din = 1'b1;
      sl_k++;
    end
  end

  logic [7:0] r_data;
  logic       r_err;
  bit         r_fell_ok;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 8; i++) p = p ^ d[i];
    return {2'b11, p, d, 1'b0};
  endfunction

  task automatic wait_rsp();
    bit prev_busy;
    prev_busy = busy;
    while (!rsp_valid) begin
      prev_busy = busy;
      @(negedge clk);
    end
    r_data    = rsp_data;
    r_err     = rsp_err;
    r_fell_ok = prev_busy && !busy;
    @(negedge clk);
    mon_en = 0;
    sl_en  = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d);
    mon_n  = 0;
    mon_en = 1;
    sl_k   = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_tx(input logic [7:0] d, input string tag);
    logic [11:0] f;
    int bad;
    f = exp_frame(d);
    bad = 0;
    for (int i = 0; i < 12; i++) if (i < mon_n && (mon_b[i] !== f[i] || mon_oe[i] !== 1'b1)) bad++;
    chk(mon_n == 12, tag, "tx rising edges", mon_n, 12);
    chk(bad == 0, tag, $sformatf("tx frame bits wrong for byte %0d", d), bad, 0);
  endtask

  task automatic rx_case(input logic [7:0] d, input int delay, input int mode, input string tag);
    logic [11:0] f;
    logic [10:0] t;
    int exp_n, badoe;
    f = exp_frame(d);
    t = f[11:1];
    if (mode == 1) t[8]  = ~t[8];
    if (mode == 2) t[9]  = 1'b0;
    if (mode == 3) t[10] = 1'b0;
    sl_frame = t;
    sl_delay = delay;
    link_din = 1'b1;
    sl_en    = 1;
    issue(2'b01, 8'h00);
    wait_rsp();
    exp_n = (delay >= 256) ? 256 : delay + 12;
    badoe = 0;
    for (int i = 0; i < mon_n && i < 320; i++) if (mon_oe[i] !== 1'b0) badoe++;
    chk(badoe == 0, "R5", "data line driven during receive", badoe, 0);
    chk(mon_n == exp_n, tag, "receive clock pulse count", mon_n, exp_n);
    if (mode == 0 && delay < 256) begin
      chk(r_err == 1'b0, tag, "rx err on good frame", r_err, 0);
      chk(r_data == d, tag, "rx data", r_data, d);
    end else begin
      chk(r_err == 1'b1, tag, $sformatf("rx err mode %0d", mode), r_err, 1);
      chk(r_data == 8'h00, tag, "rx data on error", r_data, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(link_clk == 1'b1 && link_dout == 1'b1, "R10", "line levels in reset", {link_clk, link_dout}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_clk_oe == 1'b0, "R10", "clock enable after reset", link_clk_oe, 0);
    chk(link_doe == 1'b0, "R10", "data enable after reset", link_doe, 0);
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R10", "busy/rsp after reset", {busy, rsp_valid}, 0);
    chk(cmd_ready == 1'b1, "R10", "ready after reset", cmd_ready, 1);
    chk(link_clk == 1'b1 && link_dout == 1'b1, "R10", "line levels after reset", {link_clk, link_dout}, 3);

    // R9: link entry
    begin
      int bad;
      logic [11:0] fa, fb;
      issue(2'b10, 8'h00);
      @(negedge clk);
      chk(link_dout == 1'b0 && link_clk == 1'b1 && link_clk_oe == 1'b0, "R9", "data low clock high step",
          {link_dout, link_clk, link_clk_oe}, 2);
      repeat (HD) @(negedge clk);
      chk(link_clk_oe && link_doe && !link_dout && link_clk, "R9", "enables step",
          {link_clk_oe, link_doe, link_dout, link_clk}, 13);
      repeat (HD) @(negedge clk);
      chk(link_dout && link_clk, "R9", "data raised with clock high", {link_dout, link_clk}, 3);
      wait_rsp();
      chk(mon_n == 40, "R9", "entry rising edges", mon_n, 40);
      bad = 0;
      for (int i = 0; i < 16; i++) if (mon_b[i] !== 1'b1) bad++;
      chk(bad == 0, "R9", "idle pulses with data high", bad, 0);
      fa = exp_frame(8'hC2);
      fb = exp_frame(8'h02);
      bad = 0;
      for (int i = 0; i < 12; i++) begin
        if (mon_b[16 + i] !== fa[i]) bad++;
        if (mon_b[28 + i] !== fb[i]) bad++;
      end
      chk(bad == 0, "R9", "entry frames 0xC2 then 0x02", bad, 0);
      chk(link_clk_oe && link_doe, "R9", "enables held after entry", {link_clk_oe, link_doe}, 3);
      chk(r_err == 1'b0 && r_fell_ok, "R4", "entry response", {r_err, r_fell_ok}, 1);
    end

    // R1/R2: exhaustive send sweep
    for (int v = 0; v < 256; v++) begin
      issue(2'b00, v[7:0]);
      wait_rsp();
      check_tx(v[7:0], "R1");
      chk(r_fell_ok && r_err == 1'b0, "R4", "send response with busy fall", {r_fell_ok, r_err}, 2);
      if (v == 37) begin
        int badt;
        badt = 0;
        for (int i = 0; i < 11; i++) if (mon_t[i + 1] - mon_t[i] != 2 * HD * 20) badt++;
        chk(badt == 0, "R2", "bit period in system cycles", badt, 0);
      end
    end

    // R3: request while busy is ignored
    begin
      mon_n  = 0;
      mon_en = 1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_data = 8'h5A;
      @(negedge clk);
      chk(cmd_ready == 1'b0 && busy == 1'b1, "R3", "busy after accept", {cmd_ready, busy}, 1);
      cmd_op = 2'b01; cmd_data = 8'hFF;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b0;
      wait_rsp();
      check_tx(8'h5A, "R3");
    end

    // R5/R6: exhaustive receive sweep with varied start delays
    for (int v = 0; v < 256; v++) rx_case(v[7:0], (v * 37) % 9, 0, "R6");
    rx_case(8'hA5, 255, 0, "R5");

    // R7: corrupted frames
    for (int v = 0; v < 48; v++) rx_case(v[7:0] * 5 + 3, v % 4, 1 + (v % 3), "R7");

    // R8: no start bit
    rx_case(8'h3C, 256, 0, "R8");
    rx_case(8'h00, 1000, 0, "R8");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule